// File: doc/BRIEF.md
# Four-Opcode Accumulator Execution Core

This block is a small sequential processor core. It reads one byte at a time from a program memory through a synchronous read port: it drives an address, and the data comes back one cycle later. It carries an 8-bit accumulator, an 8-bit index register, an 8-bit flag register and a program counter. Only four opcodes are decoded: load the accumulator from the next byte, copy the accumulator into the index register, increment the index register, and stop. Any other byte stops the core and raises an illegal-opcode output, so the core cannot hang.

Software-side setup happens through a preload port, which writes the accumulator and the index register while the core is not running. A start pulse then launches execution from address 0. The flag register is cleared only by reset, so its contents carry over from one run to the next. The zero flag sits at bit 1 and the negative flag at bit 7. Every instruction that writes the accumulator or the index register updates both flags from its result through one shared update path.

Top module: `acc_core`

## Requirements
- R1: After reset, reg_a, reg_x and status read 0x00, halted and illegal read 0, and mem_addr reads 0.
- R2: A start pulse while idle or halted sets mem_addr to 0 and clears halted and illegal on the next clock edge. A start pulse while a program is running has no effect on its results or its timing.
- R3: The core presents the program counter on mem_addr and uses mem_rdata one cycle later. Opcodes 0xAA, 0xE8 and 0x00 each take 2 cycles. Opcode 0xA9 takes 3 cycles. halted therefore rises a number of cycles after the start edge equal to the sum of these costs.
- R4: Opcode 0xA9 loads reg_a with the byte at the following address. The program counter then skips that operand byte. reg_a changes on the third edge of the instruction.
- R5: Opcode 0xAA copies reg_a into reg_x.
- R6: Opcode 0xE8 adds one to reg_x modulo 256, so 0xFF becomes 0x00.
- R7: After 0xA9, 0xAA or 0xE8, status bit 1 (zero) is 1 when the result is 0x00 and 0 otherwise.
- R8: After the same opcodes, status bit 7 (negative) equals bit 7 of the result. Status bits 0 and 2 to 6 never change.
- R9: Opcode 0x00 asserts halted. Once halted, mem_addr stays constant, and halted stays set until the next start.
- R10: Any opcode other than 0xA9, 0xAA, 0xE8 and 0x00 asserts both halted and illegal. The status register is left unchanged by the stop itself.
- R11: preload_en while idle or halted writes preload_a into reg_a and preload_x into reg_x, leaving status unchanged. These values survive the following start. preload_en while running is ignored.
- R12: status is cleared only by reset. A run made of a bare 0x00 leaves the status value of the previous run in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch execution at address 0 (used when idle or halted) |
| preload_en | input | 1 | Write preload values into reg_a and reg_x (used when idle or halted) |
| preload_a | input | 8 | Preload value for the accumulator |
| preload_x | input | 8 | Preload value for the index register |
| mem_addr | output | PC_W | Program memory read address |
| mem_rdata | input | 8 | Program memory read data, one cycle after the address |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index register |
| status | output | 8 | Flag register: bit 1 zero, bit 7 negative |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unsupported opcode |

## Verification
A launch edge moves the core to address 0 at once. From there, every register result and flag result of an instruction appears on the last edge of that instruction: the second edge for 0xAA and 0xE8, the third edge for 0xA9. halted rises on the second edge of the stop opcode. The bench drives and samples only on falling edges. It counts edges from the launch edge, compares the count at which halted rises with the sum of the per-opcode costs, and in one directed run checks mem_addr and reg_a edge by edge, so that a load landing one cycle early or late is caught.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int DATA_W   = 8;
  localparam int ZERO_BIT = 1;
  localparam int NEG_BIT  = 7;

  localparam logic [DATA_W-1:0] OP_LOAD_IMM = 8'hA9;
  localparam logic [DATA_W-1:0] OP_COPY_AX  = 8'hAA;
  localparam logic [DATA_W-1:0] OP_INC_X    = 8'hE8;
  localparam logic [DATA_W-1:0] OP_STOP     = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_OP, ST_FETCH_IMM, ST_EXECUTE, ST_HALT
  } core_state_e;

  typedef struct packed {
    logic load_a;
    logic copy_ax;
    logic inc_x;
    logic stop;
    logic bad_op;
  } exec_ev_t;

  function automatic logic [DATA_W-1:0] flags_after(input logic [DATA_W-1:0] st,
                                                    input logic [DATA_W-1:0] res);
    logic [DATA_W-1:0] r;
    r = st;
    r[ZERO_BIT] = (res == '0);
    r[NEG_BIT]  = res[DATA_W-1];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] inc_wrap(input logic [DATA_W-1:0] v);
    return v + DATA_W'(1);
  endfunction
endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_core_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   mem_addr,
  output exec_ev_t          ev,
  output logic              ready,
  output logic              halted,
  output logic              illegal
);
  core_state_e state, nxt;
  logic [PC_W-1:0] pc;
  logic            illegal_q;
  logic            launch;
  logic            pc_step;

  assign ready   = (state == ST_IDLE) || (state == ST_HALT);
  assign launch  = ready && start;
  assign pc_step = (state == ST_FETCH_OP) ||
                   ((state == ST_EXECUTE) && (mem_rdata == OP_LOAD_IMM));

  always_comb begin
    ev  = '0;
    nxt = state;
    case (state)
      ST_IDLE, ST_HALT: if (start) nxt = ST_FETCH_OP;
      ST_FETCH_OP:      nxt = ST_EXECUTE;
      ST_EXECUTE: begin
        case (mem_rdata)
          OP_LOAD_IMM: nxt = ST_FETCH_IMM;
          OP_COPY_AX:  begin ev.copy_ax = 1'b1; nxt = ST_FETCH_OP; end
          OP_INC_X:    begin ev.inc_x   = 1'b1; nxt = ST_FETCH_OP; end
          OP_STOP:     begin ev.stop    = 1'b1; nxt = ST_HALT;     end
          default:     begin ev.bad_op  = 1'b1; nxt = ST_HALT;     end
        endcase
      end
      ST_FETCH_IMM: begin ev.load_a = 1'b1; nxt = ST_FETCH_OP; end
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pc        <= '0;
      illegal_q <= 1'b0;
    end else begin
      state <= nxt;
      if (launch)       pc <= '0;
      else if (pc_step) pc <= pc + PC_W'(1);
      if (launch)         illegal_q <= 1'b0;
      else if (ev.bad_op) illegal_q <= 1'b1;
    end
  end

  assign mem_addr = pc;
  assign halted   = (state == ST_HALT);
  assign illegal  = illegal_q;

  p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (mem_addr == '0) && !halted && !illegal);
  p_imm_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXECUTE && mem_rdata == OP_LOAD_IMM) |=> ev.load_a);
  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));
  p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted && $stable(mem_addr));
  p_illegal_in_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  exec_ev_t          ev,
  input  logic [DATA_W-1:0] operand,
  input  logic              ready,
  input  logic              preload_en,
  input  logic [DATA_W-1:0] preload_a,
  input  logic [DATA_W-1:0] preload_x,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_x,
  output logic [DATA_W-1:0] status
);
  logic              preload_ok;
  logic [DATA_W-1:0] x_plus;

  assign preload_ok = preload_en && ready;
  assign x_plus     = inc_wrap(reg_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a  <= '0;
      reg_x  <= '0;
      status <= '0;
    end else begin
      if (preload_ok) begin
        reg_a <= preload_a;
        reg_x <= preload_x;
      end
      if (ev.load_a) begin
        reg_a  <= operand;
        status <= flags_after(status, operand);
      end
      if (ev.copy_ax) begin
        reg_x  <= reg_a;
        status <= flags_after(status, reg_a);
      end
      if (ev.inc_x) begin
        reg_x  <= x_plus;
        status <= flags_after(status, x_plus);
      end
    end
  end

  p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.copy_ax |=> reg_x == reg_a);
  p_inc_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.inc_x && reg_x == 8'hFF) |=> reg_x == 8'h00);
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.copy_ax || ev.inc_x) |=> status[ZERO_BIT] == (reg_x == '0));
  p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev.load_a |=> status[NEG_BIT] == reg_a[DATA_W-1]);
  p_other_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & 8'h7D) == ($past(status) & 8'h7D));
  p_stop_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.stop || ev.bad_op) |=> $stable(status));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            preload_en,
  input  logic [7:0]      preload_a,
  input  logic [7:0]      preload_x,
  output logic [PC_W-1:0] mem_addr,
  input  logic [7:0]      mem_rdata,
  output logic [7:0]      reg_a,
  output logic [7:0]      reg_x,
  output logic [7:0]      status,
  output logic            halted,
  output logic            illegal
);
  exec_ev_t ev;
  logic     ready;

  acc_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .ev(ev), .ready(ready), .halted(halted), .illegal(illegal)
  );

  acc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .operand(mem_rdata), .ready(ready),
    .preload_en(preload_en), .preload_a(preload_a), .preload_x(preload_x),
    .reg_a(reg_a), .reg_x(reg_x), .status(status)
  );

  p_preload_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && ready) |=> (reg_a == $past(preload_a)) && (reg_x == $past(preload_x)));
endmodule

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       preload_en = 1'b0;
  logic [7:0] preload_a = '0;
  logic [7:0] preload_x = '0;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic [7:0] reg_a, reg_x, status;
  logic       halted, illegal;
  logic [7:0] mem [256];

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .start(start), .preload_en(preload_en),
    .preload_a(preload_a), .preload_x(preload_x), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .reg_a(reg_a), .reg_x(reg_x), .status(status),
    .halted(halted), .illegal(illegal)
  );

  typedef struct packed {
    logic [63:0] prog;
    logic [7:0]  pa, px, ea, ex, est;
    logic        eill;
    logic [7:0]  cyc;
  } vec_t;

  // program bytes packed low byte first
  localparam vec_t VECS [9] = '{
    '{64'h00_E8_AA_C0_A9, 8'h00, 8'h00, 8'hC0, 8'hC1, 8'h80, 1'b0, 8'd9},
    '{64'h00_E8_E8,       8'h00, 8'hFF, 8'h00, 8'h01, 8'h00, 1'b0, 8'd6},
    '{64'h00_00_A9,       8'h44, 8'h33, 8'h00, 8'h33, 8'h02, 1'b0, 8'd5},
    '{64'h00_AA,          8'h80, 8'h00, 8'h80, 8'h80, 8'h80, 1'b0, 8'd4},
    '{64'h00_E8,          8'h00, 8'hFF, 8'h00, 8'h00, 8'h02, 1'b0, 8'd4},
    '{64'h42_81_A9,       8'h05, 8'h07, 8'h81, 8'h07, 8'h80, 1'b1, 8'd5},
    '{64'h00,             8'h11, 8'h22, 8'h11, 8'h22, 8'h80, 1'b0, 8'd2},
    '{64'h00_E8_AA_7F_A9, 8'h00, 8'h00, 8'h7F, 8'h80, 8'h80, 1'b0, 8'd9},
    '{64'h00_E8_AA_FF_A9, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h02, 1'b0, 8'd9}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_prog(input logic [63:0] prog);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) mem[i] = prog[8*i +: 8];
  endtask

  task automatic run_prog(input logic [63:0] prog, input logic [7:0] pa,
                          input logic [7:0] px, input bit disturb, output int cyc);
    load_prog(prog);
    @(negedge clk); preload_en = 1'b1; preload_a = pa; preload_x = px;
    @(negedge clk); preload_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!halted && cyc < 100) begin
      @(negedge clk); cyc++;
      if (disturb && cyc == 2) begin
        start = 1'b1; preload_en = 1'b1; preload_a = 8'h5A; preload_x = 8'hA5;
      end else begin
        start = 1'b0; preload_en = 1'b0;
      end
    end
    start = 1'b0; preload_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] hold_addr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reg_a", reg_a, 8'h00);
    chk("R1", "reg_x", reg_x, 8'h00);
    chk("R1", "status", status, 8'h00);
    chk("R1", "halted", halted, 0);
    chk("R1", "illegal", illegal, 0);
    chk("R1", "mem_addr", mem_addr, 0);

    foreach (VECS[i]) begin
      run_prog(VECS[i].prog, VECS[i].pa, VECS[i].px, 1'b0, cyc);
      chk("R3", "cycles to halt", cyc, VECS[i].cyc);
      chk("R4 R11", "reg_a", reg_a, VECS[i].ea);
      chk("R5 R6 R11", "reg_x", reg_x, VECS[i].ex);
      chk("R7 R8 R12", "status", status, VECS[i].est);
      chk("R9 R10", "halted", halted, 1);
      chk("R10", "illegal", illegal, VECS[i].eill);
    end

    // R2 R11: start and preload during a run are ignored
    run_prog(64'h00_E8_AA_C0_A9, 8'h00, 8'h00, 1'b1, cyc);
    chk("R2", "cycles with stray start", cyc, 9);
    chk("R11", "reg_a after busy preload", reg_a, 8'hC0);
    chk("R11", "reg_x after busy preload", reg_x, 8'hC1);

    // R3 R4: edge-by-edge timing of the immediate load
    load_prog(64'h00_E8_AA_C0_A9);
    @(negedge clk); preload_en = 1'b1; preload_a = 8'h11; preload_x = 8'h00;
    @(negedge clk); preload_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "addr after launch", mem_addr, 0);
    chk("R2", "halted cleared", halted, 0);
    @(negedge clk);
    chk("R3", "addr after opcode fetch", mem_addr, 1);
    @(negedge clk);
    chk("R4", "addr skips to operand", mem_addr, 2);
    chk("R4", "reg_a not yet loaded", reg_a, 8'h11);
    @(negedge clk);
    chk("R4", "reg_a loaded on third edge", reg_a, 8'hC0);
    chk("R4", "addr past operand", mem_addr, 2);
    repeat (6) @(negedge clk);
    chk("R9", "halted", halted, 1);
    chk("R9", "halt addr", mem_addr, 5);
    hold_addr = mem_addr;
    repeat (5) @(negedge clk);
    chk("R9", "addr held while halted", mem_addr, hold_addr);
    chk("R9", "still halted", halted, 1);

    // R12: only reset clears status
    chk("R12", "status before reset", status, 8'h80);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "status after reset", status, 8'h00);
    chk("R1", "halted after reset", halted, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule